// File: doc/BRIEF.md
# Buffered SPI Master with Inter-Word Gap

This block is an SPI master that sends and receives 16-bit words. Software queues outgoing words in a four-entry transmit queue and collects incoming words from a four-entry receive queue. The serial engine shifts one word at a time in mode 0, MSB first. SCLK runs at half the block clock. After every word the engine holds SCLK low for a programmable idle gap. Chip select stays asserted while further words are queued.

One 32-bit control word sets the engine enable, the queue enable, a 2-bit receive threshold code and a 13-bit gap length. The same word reports a sticky overrun flag. When the queue enable is clear, each queue holds a single word, so the block behaves as a single-buffered SPI. The receive interrupt then fires whenever a word is waiting. Clearing the queue enable empties both queues. Clearing the engine enable only stops new words from starting.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset ss_n is 1, sclk is 0, both levels are 0, rx_irq is 0 and ctrl_rdata is 0.
- R2: The control word has these fields: bits 12:0 gap length G, bit 16 queue enable, bits 19:18 threshold code, bit 20 engine enable. On read, bit 24 shows the overrun flag. Every other bit reads 0 and ignores writes.
- R3: Each word gives 16 SCLK rising edges, spaced 2 clocks apart. MOSI carries the word MSB first and is stable at each rising edge. MISO is sampled at each rising edge, and the sampled bits, MSB first, form the received word.
- R4: A word starts only while the engine enable is 1 and the transmit queue is not empty. Clearing the engine enable leaves both queue levels unchanged, and a word already in flight completes.
- R5: The last SCLK rise of one word and the first SCLK rise of the next queued word are G+3 clocks apart. ss_n stays 0 between such back-to-back words. ss_n rises once the gap ends with nothing queued.
- R6: With the queue enable set, each queue holds 4 words in first-in first-out order. A push to a full transmit queue is ignored.
- R7: With the queue enable set, rx_irq is 1 exactly when the receive level is at least the threshold. Codes 0, 1, 2 and 3 give thresholds of 1, 2, 3 and 4 words. rx_irq falls when pops bring the level below the threshold.
- R8: With the queue enable clear, each queue holds one word, the threshold code has no effect, and rx_irq is 1 whenever the receive level is nonzero.
- R9: A control write that changes the queue enable from 1 to 0 empties both queues.
- R10: A word that completes while the receive queue is full is discarded and sets the overrun flag. The flag holds until a control write with bit 24 set clears it.
- R11: A pop from an empty receive queue is ignored and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control write data |
| ctrl_rdata | output | 32 | Control read data with overrun flag |
| tx_push | input | 1 | Push tx_wdata into the transmit queue |
| tx_wdata | input | 16 | Word to transmit |
| tx_level | output | 3 | Transmit queue occupancy |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 16 | Head of the receive queue |
| rx_level | output | 3 | Receive queue occupancy |
| rx_irq | output | 1 | Receive threshold interrupt |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions take for granted that MISO changes only while SCLK is low. They also take for granted that the control word is not rewritten to disable the queues while a word is being received. The stimulus keeps to both limits. The bench slave updates MISO only on SCLK falling edges or when ss_n falls. The queue enable is cleared only after the engine has gone idle or while the one in-flight word still has many bit times left. Random rounds draw gap lengths, burst sizes and threshold codes from a fixed seed, and always preload the whole burst before setting the engine enable, so every gap measured is a true back-to-back gap.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int WORD_W     = 16;
    localparam int FIFO_DEPTH = 4;
    localparam int GAP_W      = 13;
    localparam int CTRL_W     = 32;

    localparam int BIT_QEN = 16;
    localparam int BIT_WM  = 18;
    localparam int BIT_RUN = 20;
    localparam int BIT_OVR = 24;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic             run;
        logic [1:0]       wm;
        logic             qen;
        logic [GAP_W-1:0] gap;
    } ctrl_t;

    function automatic int wm_threshold(input logic [1:0] code, input int depth);
        return (code == 2'd3) ? depth : int'(code) + 1;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             cap_one,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             empty, do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = cap_one ? !empty : (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6
    full_push_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (level == $past(level)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (level == '0));

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int W     = 16,
    parameter int GAP_W = 13,
    localparam int BIT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tx_avail,
    input  logic [W-1:0]     tx_word,
    output logic             tx_take,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             ss_n,
    output logic             rx_valid,
    output logic [W-1:0]     rx_word
);
    eng_state_e       state;
    logic             sclk_q, ss_q;
    logic [W-1:0]     tx_sh, rx_sh;
    logic [BIT_W-1:0] bit_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_done, last_bit;

    assign gap_done = (gap_cnt >= gap_len);
    assign last_bit = (bit_cnt == BIT_W'(W - 1));
    assign tx_take  = run && tx_avail &&
                      ((state == ENG_IDLE) || (state == ENG_GAP && gap_done));
    assign rx_valid = (state == ENG_SHIFT) && sclk_q && last_bit;
    assign rx_word  = rx_sh;
    assign sclk     = sclk_q;
    assign ss_n     = ss_q;
    assign mosi     = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            sclk_q  <= 1'b0;
            ss_q    <= 1'b1;
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else if (tx_take) begin
            tx_sh   <= tx_word;
            bit_cnt <= '0;
            sclk_q  <= 1'b0;
            ss_q    <= 1'b0;
            state   <= ENG_SHIFT;
        end else begin
            case (state)
                ENG_SHIFT: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[W-2:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (last_bit) begin
                            state   <= ENG_GAP;
                            gap_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[W-2:0], 1'b0};
                        end
                    end
                end
                ENG_GAP: begin
                    if (gap_done) begin
                        state <= ENG_IDLE;
                        ss_q  <= 1'b1;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: begin
                    sclk_q <= 1'b0;
                    ss_q   <= 1'b1;
                end
            endcase
        end
    end

    // R3
    sclk_select_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !ss_n);

    // R5
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_GAP) |-> (!sclk && !ss_n));

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_SHIFT && !sclk_q && $past(state == ENG_SHIFT)) |=> $stable(mosi));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int GW    = GAP_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              tx_push,
    input  logic [W-1:0]      tx_wdata,
    output logic [LVL_W-1:0]  tx_level,
    input  logic              rx_pop,
    output logic [W-1:0]      rx_rdata,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    ctrl_t        ctrl_q;
    logic         ovr_q;
    logic         flush, cap_one;
    logic         tx_full, tx_take, rx_full, rx_valid;
    logic [W-1:0] tx_head, rx_word;
    logic         unused_ctrl_bits, unused_tx_full;

    assign flush   = ctrl_we && ctrl_q.qen && !ctrl_wdata[BIT_QEN];
    assign cap_one = !ctrl_q.qen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.gap <= ctrl_wdata[GW-1:0];
                ctrl_q.qen <= ctrl_wdata[BIT_QEN];
                ctrl_q.wm  <= ctrl_wdata[BIT_WM+1:BIT_WM];
                ctrl_q.run <= ctrl_wdata[BIT_RUN];
            end
            if (rx_valid && rx_full && !flush) ovr_q <= 1'b1;
            else if (ctrl_we && ctrl_wdata[BIT_OVR]) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rdata                         = '0;
        ctrl_rdata[GW-1:0]                 = ctrl_q.gap;
        ctrl_rdata[BIT_QEN]                = ctrl_q.qen;
        ctrl_rdata[BIT_WM+1:BIT_WM]        = ctrl_q.wm;
        ctrl_rdata[BIT_RUN]                = ctrl_q.run;
        ctrl_rdata[BIT_OVR]                = ovr_q;
    end

    assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:BIT_OVR+1], ctrl_wdata[BIT_OVR-1:BIT_RUN+1],
                                ctrl_wdata[BIT_QEN+1], ctrl_wdata[BIT_QEN-1:GW]};
    assign unused_tx_full   = tx_full;

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(flush), .cap_one(cap_one),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_take),
        .rdata(tx_head), .level(tx_level), .full(tx_full)
    );

    spi_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(flush), .cap_one(cap_one),
        .push(rx_valid), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_rdata), .level(rx_level), .full(rx_full)
    );

    spi_shift_engine #(.W(W), .GAP_W(GW)) u_engine (
        .clk(clk), .rst(rst), .run(ctrl_q.run),
        .tx_avail(tx_level != '0), .tx_word(tx_head), .tx_take(tx_take),
        .gap_len(ctrl_q.gap), .miso(miso),
        .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );

    always_comb begin
        if (ctrl_q.qen) rx_irq = (int'(rx_level) >= wm_threshold(ctrl_q.wm, DEPTH));
        else            rx_irq = (rx_level != '0);
    end

    // R7
    irq_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.qen && rx_level == LVL_W'(DEPTH)) |-> rx_irq);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !(ctrl_we && ctrl_wdata[BIT_OVR])) |=> ovr_q);

    // R8
    single_cap_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.qen |-> (tx_level <= 1 && rx_level <= 1));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tx_level == '0 && rx_level == '0));

    // R4
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ss_n)) |-> $past(ctrl_q.run));

endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        tx_push = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic [2:0]  tx_level;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_rdata;
    logic [2:0]  rx_level;
    logic        rx_irq, sclk, mosi, ss_n;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nrise = 0;
    int ssn_rises = 0;
    int sidx = 0;
    int sbit = 0;
    int rise_t [4096];
    logic [15:0] cap_w [512];
    logic [15:0] mosi_sh = '0;

    always #2 clk = ~clk;

    spi_fifo_master i_spi_fifo_master (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_level(tx_level), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .rx_irq(rx_irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    function automatic logic [15:0] resp(input int i);
        logic [31:0] v;
        v = i * 32'h3B5D;
        return v[15:0] ^ 16'hC6A1;
    endfunction

    function automatic logic [31:0] ctl(input bit qen, input bit run, input int wm,
                                        input int gap, input bit clr);
        logic [31:0] v;
        v = '0;
        v[12:0]  = gap[12:0];
        v[16]    = qen;
        v[19:18] = wm[1:0];
        v[20]    = run;
        v[24]    = clr;
        return v;
    endfunction

    function automatic bit exp_irq(input bit qen, input int wm, input int lvl);
        if (!qen) return lvl != 0;
        return lvl >= ((wm == 3) ? 4 : wm + 1);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge sclk) begin
        rise_t[nrise % 4096] = cyc;
        nrise = nrise + 1;
        mosi_sh = {mosi_sh[14:0], mosi};
        if (sbit == 15) begin
            cap_w[sidx % 512] = mosi_sh;
            sidx = sidx + 1;
            sbit = 0;
        end else begin
            sbit = sbit + 1;
        end
    end

    always @(negedge sclk or negedge ss_n) begin
        logic [15:0] r;
        r = resp(sidx);
        miso = r[15 - sbit];
    end

    always @(posedge ss_n) ssn_rises = ssn_rises + 1;

    initial begin
        logic [15:0] r0;
        r0 = resp(0);
        miso = r0[15];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        tx_push = 1'b1;
        tx_wdata = d;
        @(posedge clk);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [15:0] exp);
        @(negedge clk);
        chk(req, {16'h0, rx_rdata}, {16'h0, exp});
        rx_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk);
        while (!(tx_level == 0 && ss_n == 1'b1) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] bw [4];
        int base, rb, ss0;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ss_n", {31'h0, ss_n}, 32'h1);
        chk("R1 sclk", {31'h0, sclk}, 32'h0);
        chk("R1 levels", {26'h0, tx_level, rx_level}, 32'h0);
        chk("R1 irq", {31'h0, rx_irq}, 32'h0);
        chk("R1 ctrl", ctrl_rdata, 32'h0);

        // R2 layout and reserved bits
        wr(32'hFFFF_FFFF);
        chk("R2 readback", ctrl_rdata, 32'h001D_1FFF);
        wr(ctl(1, 0, 0, 0, 0));
        chk("R2 fields", ctrl_rdata, 32'h0001_0000);

        // R6 capacity, R4 gate
        base = sidx;
        wr(ctl(1, 0, 0, 2, 0));
        for (int k = 0; k < 5; k++) begin
            logic [15:0] d;
            d = 16'(($urandom & 32'hFFFF));
            if (k < 4) bw[k] = d;
            push(d);
        end
        chk("R6 tx full ignores push", {29'h0, tx_level}, 32'd4);
        repeat (60) @(negedge clk);
        chk("R4 no start while disabled", {29'h0, tx_level}, 32'd4);
        chk("R4 ss_n idle", {31'h0, ss_n}, 32'h1);
        rb = nrise;
        ss0 = ssn_rises;
        wr(ctl(1, 1, 0, 2, 0));
        wait_idle();
        for (int k = 0; k < 4; k++) chk("R3 mosi word", {16'h0, cap_w[(base + k) % 512]}, {16'h0, bw[k]});
        chk("R3 bit spacing", rise_t[(rb + 1) % 4096] - rise_t[rb % 4096], 32'd2);
        for (int k = 1; k < 4; k++)
            chk("R5 gap", rise_t[(rb + 16*k) % 4096] - rise_t[(rb + 16*k - 1) % 4096], 32'd5);
        chk("R5 single ss_n release", ssn_rises - ss0, 32'd1);
        chk("R6 rx level", {29'h0, rx_level}, 32'd4);

        // R7 threshold sweep while draining
        for (int lvl = 4; lvl >= 1; lvl--) begin
            for (int wm = 0; wm < 4; wm++) begin
                wr(ctl(1, 0, wm, 2, 0));
                chk("R7 irq", {31'h0, rx_irq}, {31'h0, exp_irq(1, wm, lvl)});
            end
            pop_chk("R6 rx order", resp(base + 4 - lvl));
        end
        chk("R7 irq empty", {31'h0, rx_irq}, 32'h0);
        // R11 empty pop
        @(negedge clk); rx_pop = 1'b1; @(posedge clk); @(negedge clk); rx_pop = 1'b0;
        chk("R11 empty pop", {29'h0, rx_level}, 32'd0);

        // R4 clearing run keeps queue contents
        wr(ctl(1, 0, 0, 1, 0));
        push(16'h1111); push(16'h2222); push(16'h3333);
        wr(ctl(1, 1, 0, 1, 0));
        wr(ctl(1, 0, 0, 1, 0));
        repeat (80) @(negedge clk);
        chk("R4 tx kept", {29'h0, tx_level}, 32'd2);
        chk("R4 inflight done", {29'h0, rx_level}, 32'd1);

        // R9 flush
        wr(ctl(0, 0, 3, 1, 0));
        chk("R9 tx flushed", {29'h0, tx_level}, 32'd0);
        chk("R9 rx flushed", {29'h0, rx_level}, 32'd0);

        // R8 single buffer
        base = sidx;
        push(16'hA001); push(16'hA002);
        chk("R8 tx cap one", {29'h0, tx_level}, 32'd1);
        wr(ctl(0, 1, 3, 1, 0));
        wait_idle();
        chk("R8 rx one", {29'h0, rx_level}, 32'd1);
        chk("R8 irq ignores code", {31'h0, rx_irq}, 32'h1);
        chk("R3 single mosi", {16'h0, cap_w[base % 512]}, 32'h0000_A001);

        // R10 overrun
        push(16'hB00B);
        wait_idle();
        chk("R10 rx kept", {29'h0, rx_level}, 32'd1);
        chk("R10 flag set", {31'h0, ctrl_rdata[24]}, 32'h1);
        pop_chk("R10 first word kept", resp(base));
        chk("R10 flag sticky", {31'h0, ctrl_rdata[24]}, 32'h1);
        wr(ctl(0, 1, 3, 1, 1));
        chk("R10 flag cleared", {31'h0, ctrl_rdata[24]}, 32'h0);

        // Random rounds
        for (int rnd = 0; rnd < 12; rnd++) begin
            int g, n, wm;
            g = $urandom % 8;
            n = 1 + ($urandom % 4);
            wm = $urandom % 4;
            base = sidx;
            wr(ctl(1, 0, wm, g, 0));
            for (int k = 0; k < n; k++) begin
                bw[k] = 16'(($urandom & 32'hFFFF));
                push(bw[k]);
            end
            rb = nrise;
            ss0 = ssn_rises;
            wr(ctl(1, 1, wm, g, 0));
            wait_idle();
            for (int k = 0; k < n; k++) begin
                chk("R3 rnd mosi", {16'h0, cap_w[(base + k) % 512]}, {16'h0, bw[k]});
                if (k > 0)
                    chk("R5 rnd gap", rise_t[(rb + 16*k) % 4096] - rise_t[(rb + 16*k - 1) % 4096], g + 3);
            end
            chk("R5 rnd release", ssn_rises - ss0, 32'd1);
            chk("R7 rnd irq", {31'h0, rx_irq}, {31'h0, exp_irq(1, wm, n)});
            for (int k = 0; k < n; k++) pop_chk("R3 rnd rx", resp(base + k));
            wr(ctl(1, 0, wm, g, 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule